// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor from normal execution into an exception handler. When a request is accepted it captures the current status word, program counter and supervisor stack pointer. It builds the new status word with supervisor mode on and tracing off. It then pushes a four-word short frame onto the supervisor stack. Last, it reads the handler address from the vector table, at the vector base plus four times the vector number. The caller supplies the vector number. For an interrupt, that number comes from the interrupt controller. For any other exception, it comes from the core's own cause logic.

After reset the block runs a cold-start path on its own. This path writes nothing. It reads four words from address zero: the first two give the initial stack pointer and the last two give the initial program counter. All memory traffic uses a single 16-bit word port, with a request that is held until it is acknowledged. The block returns its results on `sr_o`, `pc_o` and `ssp_o`. `done` marks the cycle in which they are final.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset is released, the block reads the words at addresses 0, 2, 4 and 6 in that order and writes nothing. It forms `ssp_o` from the first two words and `pc_o` from the last two, high word first in each case.
- R2: The cold-start path ends with `sr_o` = 16'h2700 (supervisor set, trace clear, mask 7), and `vbr_clr` is high in the same cycle as `done`.
- R3: `start` is accepted only while `busy` is low. A `start` pulse during a sequence has no effect on that sequence's memory traffic or its results.
- R4: For an accepted request, `sr_o` equals `sr_in` with bit 15 cleared and bit 13 set. Bits 10:8 are replaced by `lvl_in` when `irq_in` is 1 and are kept otherwise.
- R5: Exactly four words are written: the low half of the PC at `ssp_in`-2, the high half at `ssp_in`-4, the unmodified `sr_in` at `ssp_in`-6, and the format/offset word at `ssp_in`-8. At the end, `ssp_o` = `ssp_in`-8.
- R6: The format/offset word has format 0000 in bits 15:12 and the vector number times four in bits 11:0.
- R7: The handler address is read from `vbr_in`+4·`vec_in` and then from the address 2 above it. `pc_o` is the first word concatenated with the second.
- R8: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold steady. Each acknowledge completes exactly one word.
- R9: `done` is a one-cycle pulse in the cycle after the final acknowledge. `busy` is high from the cycle after acceptance until that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release starts the cold-start path |
| start | input | 1 | Exception entry request |
| irq_in | input | 1 | Request is an interrupt |
| lvl_in | input | 3 | Level of the interrupt being acknowledged |
| vec_in | input | VEC_W | Vector number |
| sr_in | input | 16 | Current status word |
| pc_in | input | 32 | PC to be saved |
| ssp_in | input | 32 | Current supervisor stack pointer |
| vbr_in | input | 32 | Vector table base |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Results valid, one-cycle pulse |
| vbr_clr | output | 1 | Vector base must be cleared (cold start) |
| sr_o | output | 16 | New status word |
| pc_o | output | 32 | Handler address |
| ssp_o | output | 32 | New supervisor stack pointer |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Word transfer completes at this edge |

## Verification
Most internal state in this block can be seen at the memory port within one transfer. A step counter or stack pointer that is off by one shows up at once as a wrong address or a wrong payload in the frame. A wrong choice of vector base shows up at the first fetch address. A wrong snapshot or a wrong byte lane only becomes visible in the pushed words or in `pc_o`/`ssp_o` at `done`. The bench covers every vector number, with varying acknowledge latency and both request kinds, so each field of every word is compared on every run.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             irq_in,
  input  logic [2:0]       lvl_in,
  input  logic [VEC_W-1:0] vec_in,
  input  logic [15:0]      sr_in,
  input  logic [31:0]      pc_in,
  input  logic [31:0]      ssp_in,
  input  logic [31:0]      vbr_in,
  output logic             busy,
  output logic             done,
  output logic             vbr_clr,
  output logic [15:0]      sr_o,
  output logic [31:0]      pc_o,
  output logic [31:0]      ssp_o,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [15:0]      mem_wdata,
  input  logic [15:0]      mem_rdata,
  input  logic             mem_ack
);

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_FETCH} st_t;

  st_t             st;
  logic [1:0]      step;
  logic            boot;
  logic [31:0]     sp, pc_r, pc_sv, vbr_r;
  logic [15:0]     sr_r, sr_sv;
  logic [VEC_W-1:0] vec_r;
  logic            done_r;

  logic [31:0] sp_dec, vaddr;
  logic [1:0]  widx;

  assign sp_dec = sp - 32'd2;
  assign widx   = boot ? step : step + 2'd2;
  assign vaddr  = (boot ? 32'd0 : vbr_r + 32'({vec_r, 2'b00})) + 32'({step, 1'b0});

  assign busy     = st != S_IDLE;
  assign mem_req  = st != S_IDLE;
  assign mem_we   = st == S_PUSH;
  assign mem_addr = (st == S_PUSH) ? sp_dec : vaddr;
  assign done     = done_r;
  assign vbr_clr  = done_r & boot;
  assign sr_o     = sr_r;
  assign pc_o     = pc_r;
  assign ssp_o    = sp;

  always_comb begin
    case (step)
      2'd0:    mem_wdata = pc_sv[15:0];
      2'd1:    mem_wdata = pc_sv[31:16];
      2'd2:    mem_wdata = sr_sv;
      default: mem_wdata = 16'({vec_r, 2'b00});
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_FETCH; boot <= 1'b1; step <= 2'd0; done_r <= 1'b0;
      sp <= '0; pc_r <= '0; pc_sv <= '0; vbr_r <= '0;
      sr_r <= 16'h2700; sr_sv <= '0; vec_r <= '0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st    <= S_PUSH;
          boot  <= 1'b0;
          step  <= 2'd0;
          sp    <= ssp_in;
          pc_sv <= pc_in;
          sr_sv <= sr_in;
          vbr_r <= vbr_in;
          vec_r <= vec_in;
          sr_r  <= {1'b0, sr_in[14], 1'b1, sr_in[12:11],
                    irq_in ? lvl_in : sr_in[10:8], sr_in[7:0]};
        end
        S_PUSH: if (mem_ack) begin
          sp   <= sp_dec;
          step <= step + 2'd1;
          if (step == 2'd3) st <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          case (widx)
            2'd0: sp[31:16]   <= mem_rdata;
            2'd1: sp[15:0]    <= mem_rdata;
            2'd2: pc_r[31:16] <= mem_rdata;
            default: pc_r[15:0] <= mem_rdata;
          endcase
          step <= step + 2'd1;
          if (widx == 2'd3) begin
            st     <= S_IDLE;
            done_r <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_push_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> !mem_we || mem_addr == $past(mem_addr) - 32'd2);

  p_mode_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sr_o[13] && !sr_o[15]);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req);

  p_boot_nowrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !vbr_clr);

endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, irq_in = 1'b0;
  logic [2:0]  lvl_in = '0;
  logic [7:0]  vec_in = '0;
  logic [15:0] sr_in = '0;
  logic [31:0] pc_in = '0, ssp_in = '0, vbr_in = '0;
  logic        busy, done, vbr_clr, mem_req, mem_we;
  logic [15:0] sr_o, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic [31:0] pc_o, ssp_o, mem_addr;

  int n_chk = 0, n_fail = 0;
  int lat = 0, wcnt = 0, nw = 0, nr = 0;
  logic [31:0] wa [0:7];
  logic [15:0] wd [0:7];
  logic [31:0] ra [0:7];

  always #5 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .irq_in(irq_in), .lvl_in(lvl_in),
    .vec_in(vec_in), .sr_in(sr_in), .pc_in(pc_in), .ssp_in(ssp_in), .vbr_in(vbr_in),
    .busy(busy), .done(done), .vbr_clr(vbr_clr), .sr_o(sr_o), .pc_o(pc_o),
    .ssp_o(ssp_o), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  function automatic logic [15:0] fmem(input logic [31:0] a);
    return (a[15:0] * 16'd7) ^ a[31:16] ^ 16'h5A3C;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; wcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        mem_rdata = fmem(mem_addr);
        if (mem_we) begin
          if (nw < 8) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; end
          nw++;
        end else begin
          if (nr < 8) ra[nr] = mem_addr;
          nr++;
        end
      end else wcnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    chk("R9 reset done low", {31'd0, done}, 32'd0);
    chk("R2 reset vbr_clr low", {31'd0, vbr_clr}, 32'd0);
    rst_n = 1'b1;
    wait_done(ok);
    chk("R1 cold start finished", {31'd0, ok}, 32'd1);
    chk("R1 no writes", nw, 0);
    chk("R1 read count", nr, 4);
    for (int k = 0; k < 4; k++) chk("R1 read address", ra[k], 32'(2 * k));
    chk("R1 stack pointer", ssp_o, {fmem(0), fmem(2)});
    chk("R1 program counter", pc_o, {fmem(4), fmem(6)});
    chk("R2 status word", {16'd0, sr_o}, 32'h2700);
    chk("R2 vbr_clr with done", {31'd0, vbr_clr}, 32'd1);
    @(negedge clk);
    chk("R9 done one cycle", {31'd0, done}, 32'd0);

    for (int v = 0; v < 256; v++) begin
      logic [15:0] e_sr, s_in;
      logic [31:0] e_pc, p_in, sp_in, vb_in, a0;
      logic        irq;
      logic [2:0]  lv;
      irq   = v[0];
      lv    = 3'(v >> 1);
      s_in  = 16'(v * 16'h0101) ^ ((v % 3 == 0) ? 16'h8000 : 16'h0000);
      p_in  = {8'(v), 24'h13579B} ^ 32'(v * 5);
      sp_in = 32'h0000_8000 + 32'(v * 16);
      vb_in = 32'h0001_0000 * 32'(v % 4) + 32'(v % 5) * 32'h400;
      lat   = v % 3;
      nw = 0; nr = 0;
      irq_in = irq; lvl_in = lv; vec_in = 8'(v); sr_in = s_in;
      pc_in = p_in; ssp_in = sp_in; vbr_in = vb_in;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9 busy after accept", {31'd0, busy}, 32'd1);
      @(negedge clk);
      start = 1'b1; vec_in = ~8'(v); sr_in = ~s_in; pc_in = ~p_in;
      ssp_in = ~sp_in; vbr_in = ~vb_in; irq_in = ~irq;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      chk("R9 sequence finished", {31'd0, ok}, 32'd1);
      chk("R9 busy low at done", {31'd0, busy}, 32'd0);
      chk("R2 vbr_clr low for exceptions", {31'd0, vbr_clr}, 32'd0);
      chk("R8 write count", nw, 4);
      chk("R8 read count", nr, 2);
      chk("R5 push 0 address", wa[0], sp_in - 32'd2);
      chk("R5 push 0 PC low", {16'd0, wd[0]}, {16'd0, p_in[15:0]});
      chk("R5 push 1 address", wa[1], sp_in - 32'd4);
      chk("R5 push 1 PC high", {16'd0, wd[1]}, {16'd0, p_in[31:16]});
      chk("R5 push 2 address", wa[2], sp_in - 32'd6);
      chk("R5 push 2 status", {16'd0, wd[2]}, {16'd0, s_in});
      chk("R6 push 3 address", wa[3], sp_in - 32'd8);
      chk("R6 format/offset", {16'd0, wd[3]}, 32'(v * 4));
      chk("R5 final stack pointer", ssp_o, sp_in - 32'd8);
      a0 = vb_in + 32'(v * 4);
      chk("R7 fetch high address", ra[0], a0);
      chk("R7 fetch low address", ra[1], a0 + 32'd2);
      e_pc = {fmem(a0), fmem(a0 + 32'd2)};
      chk("R7 new PC", pc_o, e_pc);
      e_sr = (s_in & ~16'h8000) | 16'h2000;
      if (irq) e_sr = (e_sr & ~16'h0700) | {5'd0, lv, 8'd0};
      chk("R4 new status", {16'd0, sr_o}, {16'd0, e_sr});
      chk("R3 no restart after done", {31'd0, busy}, 32'd0);
      @(negedge clk);
      chk("R9 done pulse width", {31'd0, done}, 32'd0);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule